// File: doc/BRIEF.md
# ADC Conversion and Readout Sequencer

This block runs an eight-channel successive-approximation ADC that has a separate conversion-start pin and an SPI readout port. A sample request raises the convert line for a fixed number of clock cycles. The block then waits out the worst-case conversion time and runs one 24-bit full-duplex SPI frame. During that frame it sends the control word for the following conversion and receives the result of the current one. Every result packet goes into a 16-entry FIFO, and the consumer drains that FIFO at its own pace.

The block has three command modes. A single sample runs one convert/readout cycle. A burst repeats the cycle a given number of times, with a programmable spacing between sample starts. A configure command sends one 8-bit control word as its own short frame. The ADC chip select stays low from one configure word to the next until a word flagged as last has been sent, so a whole list of words reaches the converter as one transaction. The ADC owns one line of a small chip-select vector, and the other lines stay idle.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the convert line and SCLK are low, every chip-select line is high, busy is low, the FIFO is empty and the overflow flag is clear.
- R2: An accepted sample or burst start raises the convert line on the next cycle and holds it high for exactly CNV_HI_CYC cycles (default 4).
- R3: The ADC chip select (active low, index ADC_CS = 1) falls exactly CNV_WAIT_CYC cycles (default 56) after the convert line falls. Chip-select lines other than ADC_CS never go low.
- R4: A readout frame has 24 SCLK rising edges, SCLK idles low (mode 0), and bits go MSB first. MOSI carries the 8-bit control word (valid in bit 7, channel in bits 5:3, span in bits 2:0) in the first 8 bits, followed by 16 zero bits.
- R5: MISO is sampled on each SCLK rising edge, MSB first. The 24-bit packet (sample in bits 23:8, channel in 5:3, span in 2:0) is pushed into the FIFO, and fifo_data shows the oldest entry while fifo_empty is low.
- R6: busy is high from an accepted start until the command's last frame completes. A start given while busy is high is ignored.
- R7: mode 1 (burst) runs burst_len samples. Successive convert rising edges are burst_ivl cycles apart. If burst_ivl is below the minimum sample time of CNV_HI_CYC + CNV_WAIT_CYC + 24·SPI_DIV + 1 cycles (253 by default), they are that minimum apart instead.
- R8: A burst start with burst_len = 0 is ignored: no convert pulse, no frame, busy stays low.
- R9: mode 2 (configure) sends ctrl_word as an 8-bit frame. The ADC chip select stays low between configure words and rises only after a word sent with cfg_last = 1. While such a transaction is open, sample (mode 0) and burst starts are ignored. Mode 3 is ignored in all cases.
- R10: The FIFO holds 16 packets. A result that arrives while the FIFO is full and not being read is dropped, and fifo_ovf is set and stays set until reset.
- R11: A result that arrives in the same cycle as a read of a full FIFO is stored. The count stays at 16 and fifo_ovf is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| mode | input | 2 | 0 sample, 1 burst, 2 configure, 3 none |
| ctrl_word | input | 8 | Control word to send |
| cfg_last | input | 1 | Configure word closes the transaction |
| burst_len | input | LEN_W | Number of burst samples |
| burst_ivl | input | IVL_W | Cycles between burst sample starts |
| busy | output | 1 | Command in progress |
| adc_cnv | output | 1 | Convert-start pulse to the ADC |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the ADC |
| spi_miso | input | 1 | SPI data from the ADC |
| spi_cs_n | output | NCS | Active-low chip selects |
| fifo_rd | input | 1 | Pop the oldest result |
| fifo_data | output | 24 | Oldest result packet |
| fifo_empty | output | 1 | FIFO holds no result |
| fifo_cnt | output | CNT_W | Number of stored results |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
A result push from a finished readout and a pop by the consumer can happen in the same clock cycle, and the hard case is a full FIFO. The bench fills the FIFO to 16 entries with a burst. It then issues one more sample and raises fifo_rd for a single cycle, placed by counting the 253 cycles from the accepted start to the push edge. The check passes when the popped value is the oldest packet, the count is still 16, the overflow flag is clear, and the new packet turns up last when the FIFO is drained. A further sample with no read must then set the flag and be dropped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SAMPLE = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_CONFIG = 2'd2,
    MODE_NONE   = 2'd3
  } seq_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CNV, S_WAIT, S_XFER, S_GAP, S_CFG
  } seq_state_e;

  localparam int FRAME_BITS = 24;
  localparam int CTRL_BITS  = 8;
endpackage

// File: rtl/adc_spi_xfer.sv
module adc_spi_xfer #(
  parameter int SPI_DIV = 8,
  parameter int FW      = 24,
  parameter int NB_W    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [NB_W-1:0] nbits,
  input  logic [FW-1:0]   tx,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [FW-1:0]   rx
);
  localparam int HALF = SPI_DIV / 2;
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic            act_q, act_n, sclk_q, sclk_n, done_q, done_n;
  logic [HC_W-1:0] hc_q, hc_n;
  logic [NB_W-1:0] bc_q, bc_n, nb_q, nb_n;
  logic [FW-1:0]   sh_q, sh_n, rx_q, rx_n;

  always_comb begin
    act_n  = act_q;
    sclk_n = sclk_q;
    done_n = 1'b0;
    hc_n   = hc_q;
    bc_n   = bc_q;
    nb_n   = nb_q;
    sh_n   = sh_q;
    rx_n   = rx_q;
    if (!act_q) begin
      if (go) begin
        act_n  = 1'b1;
        sclk_n = 1'b0;
        hc_n   = '0;
        bc_n   = '0;
        nb_n   = nbits;
        sh_n   = tx;
        rx_n   = '0;
      end
    end else if (hc_q == HC_W'(HALF - 1)) begin
      hc_n = '0;
      if (!sclk_q) begin
        sclk_n = 1'b1;
        rx_n   = {rx_q[FW-2:0], miso};
      end else begin
        sclk_n = 1'b0;
        sh_n   = sh_q << 1;
        if (bc_q == nb_q - NB_W'(1)) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end else begin
          bc_n = bc_q + NB_W'(1);
        end
      end
    end else begin
      hc_n = hc_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      hc_q   <= '0;
      bc_q   <= '0;
      nb_q   <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_n;
      sclk_q <= sclk_n;
      done_q <= done_n;
      hc_q   <= hc_n;
      bc_q   <= bc_n;
      nb_q   <= nb_n;
      sh_q   <= sh_n;
      rx_q   <= rx_n;
    end
  end

  assign sclk = sclk_q;
  assign mosi = act_q & sh_q[FW-1];
  assign busy = act_q | done_q;
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNV_HI_CYC   = 4,
  parameter int CNV_WAIT_CYC = 56,
  parameter int LEN_W        = 8,
  parameter int IVL_W        = 16,
  parameter int FW           = 24,
  parameter int CW           = 8,
  parameter int NB_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CW-1:0]    ctrl_word,
  input  logic             cfg_last,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [IVL_W-1:0] burst_ivl,
  input  logic             xfer_done,
  output logic             busy,
  output logic             cnv,
  output logic             xfer_go,
  output logic [NB_W-1:0]  xfer_nbits,
  output logic [FW-1:0]    xfer_tx,
  output logic             cfg_open,
  output logic             push
);
  localparam int TMAX = (CNV_HI_CYC > CNV_WAIT_CYC) ? CNV_HI_CYC : CNV_WAIT_CYC;
  localparam int TC_W = $clog2(TMAX + 1);

  seq_mode_e        md;
  seq_state_e       st_q, st_n;
  logic [TC_W-1:0]  tc_q, tc_n;
  logic [IVL_W-1:0] ic_q, ic_n, iv_q, iv_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic [CW-1:0]    cw_q, cw_n;
  logic             last_q, last_n, open_q, open_n, cnv_q;
  logic [IVL_W:0]   ic_inc;
  logic             ivl_due;

  assign md      = seq_mode_e'(mode);
  assign ic_inc  = {1'b0, ic_q} + (IVL_W + 1)'(1);
  assign ivl_due = ic_inc >= {1'b0, iv_q};

  always_comb begin
    st_n   = st_q;
    tc_n   = tc_q;
    ic_n   = (&ic_q) ? ic_q : ic_q + IVL_W'(1);
    iv_n   = iv_q;
    rem_n  = rem_q;
    cw_n   = cw_q;
    last_n = last_q;
    open_n = open_q;
    xfer_go = 1'b0;
    push    = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        if (md == MODE_CONFIG) begin
          xfer_go = 1'b1;
          st_n    = S_CFG;
          last_n  = cfg_last;
        end else if (!open_q && (md == MODE_SAMPLE ||
                     (md == MODE_BURST && burst_len != '0))) begin
          st_n  = S_CNV;
          tc_n  = '0;
          ic_n  = '0;
          rem_n = (md == MODE_SAMPLE) ? LEN_W'(1) : burst_len;
          cw_n  = ctrl_word;
          iv_n  = burst_ivl;
        end
      end
      S_CNV: if (tc_q == TC_W'(CNV_HI_CYC - 1)) begin
        st_n = S_WAIT;
        tc_n = '0;
      end else begin
        tc_n = tc_q + TC_W'(1);
      end
      S_WAIT: if (tc_q == TC_W'(CNV_WAIT_CYC - 1)) begin
        xfer_go = 1'b1;
        st_n    = S_XFER;
        tc_n    = '0;
      end else begin
        tc_n = tc_q + TC_W'(1);
      end
      S_XFER: if (xfer_done) begin
        push  = 1'b1;
        rem_n = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) begin
          st_n = S_IDLE;
        end else if (ivl_due) begin
          st_n = S_CNV;
          tc_n = '0;
          ic_n = '0;
        end else begin
          st_n = S_GAP;
        end
      end
      S_GAP: if (ivl_due) begin
        st_n = S_CNV;
        tc_n = '0;
        ic_n = '0;
      end
      S_CFG: if (xfer_done) begin
        st_n   = S_IDLE;
        open_n = !last_q;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tc_q   <= '0;
      ic_q   <= '0;
      iv_q   <= '0;
      rem_q  <= '0;
      cw_q   <= '0;
      last_q <= 1'b0;
      open_q <= 1'b0;
      cnv_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      tc_q   <= tc_n;
      ic_q   <= ic_n;
      iv_q   <= iv_n;
      rem_q  <= rem_n;
      cw_q   <= cw_n;
      last_q <= last_n;
      open_q <= open_n;
      cnv_q  <= (st_n == S_CNV);
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign cnv        = cnv_q;
  assign cfg_open   = open_q;
  assign xfer_nbits = (st_q == S_IDLE) ? NB_W'(CW) : NB_W'(FW);
  assign xfer_tx    = {((st_q == S_IDLE) ? ctrl_word : cw_q), (FW - CW)'(0)};
endmodule

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ovf_q, ovf_n, push_ok, pop_ok, full;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);
  assign push_ok = push && (!full || pop_ok);

  always_comb begin
    wp_n  = push_ok ? ptr_inc(wp_q) : wp_q;
    rp_n  = pop_ok ? ptr_inc(rp_q) : rp_q;
    ovf_n = ovf_q | (push & ~push_ok);
    case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt_q + CNT_W'(1);
      2'b01:   cnt_n = cnt_q - CNT_W'(1);
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign cnt   = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CNV_HI_CYC   = 4,
  parameter int CNV_WAIT_CYC = 56,
  parameter int SPI_DIV      = 8,
  parameter int NCS          = 3,
  parameter int ADC_CS       = 1,
  parameter int FIFO_DEPTH   = 16,
  parameter int LEN_W        = 8,
  parameter int IVL_W        = 16,
  localparam int CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic [CTRL_BITS-1:0]  ctrl_word,
  input  logic                  cfg_last,
  input  logic [LEN_W-1:0]      burst_len,
  input  logic [IVL_W-1:0]      burst_ivl,
  output logic                  busy,
  output logic                  adc_cnv,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic [NCS-1:0]        spi_cs_n,
  input  logic                  fifo_rd,
  output logic [FRAME_BITS-1:0] fifo_data,
  output logic                  fifo_empty,
  output logic [CNT_W-1:0]      fifo_cnt,
  output logic                  fifo_ovf
);
  localparam int NB_W = $clog2(FRAME_BITS + 1);

  logic [1:0]            rs_q;
  logic                  rst_i;
  logic                  x_go, x_busy, x_done, cfg_open, push, adc_sel;
  logic [NB_W-1:0]       x_nbits;
  logic [FRAME_BITS-1:0] x_tx, x_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  adc_seq_ctrl #(
    .CNV_HI_CYC(CNV_HI_CYC), .CNV_WAIT_CYC(CNV_WAIT_CYC), .LEN_W(LEN_W),
    .IVL_W(IVL_W), .FW(FRAME_BITS), .CW(CTRL_BITS), .NB_W(NB_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(start), .mode(mode),
    .ctrl_word(ctrl_word), .cfg_last(cfg_last), .burst_len(burst_len),
    .burst_ivl(burst_ivl), .xfer_done(x_done), .busy(busy), .cnv(adc_cnv),
    .xfer_go(x_go), .xfer_nbits(x_nbits), .xfer_tx(x_tx),
    .cfg_open(cfg_open), .push(push)
  );

  adc_spi_xfer #(.SPI_DIV(SPI_DIV), .FW(FRAME_BITS), .NB_W(NB_W)) u_xfer (
    .clk(clk), .rst_n(rst_i), .go(x_go), .nbits(x_nbits), .tx(x_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .busy(x_busy),
    .done(x_done), .rx(x_rx)
  );

  adc_res_fifo #(.DEPTH(FIFO_DEPTH), .W(FRAME_BITS), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(push), .din(x_rx), .pop(fifo_rd),
    .dout(fifo_data), .empty(fifo_empty), .cnt(fifo_cnt), .ovf(fifo_ovf)
  );

  assign adc_sel = x_busy | cfg_open;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    if (g == ADC_CS) begin : g_adc
      assign spi_cs_n[g] = ~adc_sel;
    end else begin : g_idle
      assign spi_cs_n[g] = 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NCS    = 3,
  parameter int ADC_CS = 1,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_cnv,
  input logic             busy,
  input logic             spi_sclk,
  input logic [NCS-1:0]   spi_cs_n,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fifo_ovf
);
  // R3: the converter is never selected while a conversion is being started
  a_r3_cs_off_during_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv |-> spi_cs_n[ADC_CS]);

  // R4: SCLK rests low whenever the ADC is deselected
  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n[ADC_CS] |-> !spi_sclk);

  // R6: a convert pulse only occurs inside a busy command
  a_r6_busy_covers_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv |-> busy);

  // R10: overflow flag is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  // R10: occupancy never exceeds the depth
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH);

  // R11: count changes by at most one per cycle
  a_r11_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt != $past(fifo_cnt)) |->
      (fifo_cnt == $past(fifo_cnt) + CNT_W'(1) || fifo_cnt == $past(fifo_cnt) - CNT_W'(1)));
endmodule

bind adc_seq_top adc_seq_chk #(
  .NCS(NCS), .ADC_CS(ADC_CS), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cnv(adc_cnv), .busy(busy),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .fifo_cnt(fifo_cnt),
  .fifo_ovf(fifo_ovf)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam int MIN_PER = 4 + 56 + 24 * 8 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  ctrl_word = 8'h00;
  logic        cfg_last = 1'b0;
  logic [7:0]  burst_len = 8'd0;
  logic [15:0] burst_ivl = 16'd0;
  logic        busy, adc_cnv, spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs_n;
  logic        fifo_rd = 1'b0;
  logic [23:0] fifo_data;
  logic        fifo_empty, fifo_ovf;
  logic [4:0]  fifo_cnt;

  always #5 clk = ~clk;

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .ctrl_word(ctrl_word), .cfg_last(cfg_last), .burst_len(burst_len),
    .burst_ivl(burst_ivl), .busy(busy), .adc_cnv(adc_cnv),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .fifo_rd(fifo_rd), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt), .fifo_ovf(fifo_ovf)
  );

  int nchk = 0;
  int nerr = 0;

  function automatic logic [23:0] pat(input int i);
    logic [15:0] s;
    s = 16'h1234 + 16'(i) * 16'h0F1D;
    return {s, 2'b00, 3'(i), 3'(i + 3)};
  endfunction

  // monitors on the clock
  int cyc = 0;
  int n_rise = 0, last_rise = 0, hi_cnt = 0, last_hi = 0, t_fall = 0;
  int last_wait = 0, n_csfall = 0;
  int gap_arr [0:63];
  logic cnv_prev = 1'b0, cs_prev = 1'b1, other_low = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (adc_cnv && !cnv_prev) begin
      if (n_rise > 0 && n_rise < 64) gap_arr[n_rise] = cyc - last_rise;
      last_rise = cyc;
      n_rise++;
      hi_cnt = 0;
    end
    if (adc_cnv) hi_cnt++;
    if (!adc_cnv && cnv_prev) begin
      last_hi = hi_cnt;
      t_fall = cyc;
    end
    if (!spi_cs_n[1] && cs_prev) begin
      last_wait = cyc - t_fall;
      n_csfall++;
    end
    if (rst_n && (!spi_cs_n[0] || !spi_cs_n[2])) other_low = 1'b1;
    cnv_prev = adc_cnv;
    cs_prev = spi_cs_n[1];
  end

  // SPI slave model
  int tot_bits = 0, tot_fall = 0, bits0 = 0, fall0 = 0, last_bits = 0, fr = 0;
  logic [63:0] mosi_hist = '0;
  logic [23:0] last_mosi = '0, cur_pat = '0;
  wire cs1 = spi_cs_n[1];

  always @(posedge spi_sclk) begin
    tot_bits++;
    mosi_hist = {mosi_hist[62:0], spi_mosi};
  end
  always @(negedge spi_sclk) tot_fall++;
  always @(negedge cs1) begin
    bits0 = tot_bits;
    fall0 = tot_fall;
    cur_pat = pat(fr);
  end
  always @(posedge cs1) begin
    last_bits = tot_bits - bits0;
    last_mosi = mosi_hist[23:0];
    fr++;
  end
  assign spi_miso = ((tot_fall - fall0) < 24) ? cur_pat[23 - (tot_fall - fall0)] : 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic do_start(input logic [1:0] m, input logic [7:0] cw,
                          input logic lst, input logic [7:0] len, input logic [15:0] ivl);
    @(negedge clk);
    start = 1'b1; mode = m; ctrl_word = cw; cfg_last = lst;
    burst_len = len; burst_ivl = ivl;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    settle();
  endtask

  task automatic pop(output logic [23:0] d);
    @(negedge clk);
    d = fifo_data;
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  localparam logic [7:0] VEC_CTRL [0:3] = '{8'h87, 8'h8F, 8'hB5, 8'h00};

  initial begin
    logic [23:0] d;
    int f0, n0, c0, fb;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 cnv", adc_cnv, 0);
    check("R1 cs", spi_cs_n, 3'b111);
    check("R1 sclk", spi_sclk, 0);
    check("R1 busy", busy, 0);
    check("R1 empty", fifo_empty, 1);
    check("R1 ovf", fifo_ovf, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table of single samples: R2 R3 R4 R5
    for (int i = 0; i < 4; i++) begin
      f0 = fr;
      do_start(2'd0, VEC_CTRL[i], 1'b0, 8'd0, 16'd0);
      wait_idle();
      check("R2 cnv width", last_hi, 4);
      check("R3 wait", last_wait, 56);
      check("R4 bits", last_bits, 24);
      check("R4 mosi", last_mosi, {VEC_CTRL[i], 16'h0000});
      check("R5 cnt", fifo_cnt, 1);
      pop(d);
      check("R5 data", d, pat(f0));
      settle();
      check("R5 empty", fifo_empty, 1);
    end
    check("R3 other cs", other_low, 0);

    // R6 busy and ignored start
    f0 = fr; n0 = n_rise;
    do_start(2'd0, 8'h91, 1'b0, 8'd0, 16'd0);
    repeat (20) @(negedge clk);
    check("R6 busy", busy, 1);
    do_start(2'd0, 8'hAA, 1'b0, 8'd0, 16'd0);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R6 one pulse", n_rise - n0, 1);
    check("R6 mosi", last_mosi, 24'h910000);
    check("R6 cnt", fifo_cnt, 1);
    pop(d);
    check("R6 data", d, pat(f0));

    // R7 burst with long interval
    f0 = fr; n0 = n_rise;
    do_start(2'd1, 8'hC8, 1'b0, 8'd3, 16'd300);
    wait_idle();
    check("R7 count", n_rise - n0, 3);
    check("R7 gap1", gap_arr[n0 + 1], 300);
    check("R7 gap2", gap_arr[n0 + 2], 300);
    check("R7 fifo", fifo_cnt, 3);
    for (int k = 0; k < 3; k++) begin
      pop(d);
      check("R7 data", d, pat(f0 + k));
    end
    // R7 burst with interval below the minimum
    n0 = n_rise;
    do_start(2'd1, 8'hC8, 1'b0, 8'd2, 16'd40);
    wait_idle();
    check("R7 min gap", gap_arr[n0 + 1], MIN_PER);
    pop(d); pop(d);

    // R8 zero length burst
    n0 = n_rise;
    do_start(2'd1, 8'hC8, 1'b0, 8'd0, 16'd10);
    settle();
    check("R8 busy", busy, 0);
    repeat (10) @(negedge clk);
    check("R8 no pulse", n_rise - n0, 0);
    check("R8 cs", spi_cs_n[1], 1);

    // R9 configure transaction
    c0 = n_csfall; n0 = n_rise;
    do_start(2'd2, 8'h81, 1'b0, 8'd0, 16'd0);
    wait_idle();
    check("R9 cs held", spi_cs_n[1], 0);
    do_start(2'd0, 8'h87, 1'b0, 8'd0, 16'd0);
    repeat (80) @(negedge clk);
    check("R9 sample ignored", n_rise - n0, 0);
    do_start(2'd3, 8'h55, 1'b1, 8'd0, 16'd0);
    settle();
    check("R9 mode3 ignored", busy, 0);
    do_start(2'd2, 8'h8A, 1'b0, 8'd0, 16'd0);
    wait_idle();
    do_start(2'd2, 8'h93, 1'b1, 8'd0, 16'd0);
    wait_idle();
    check("R9 cs released", spi_cs_n[1], 1);
    check("R9 one select", n_csfall - c0, 1);
    check("R9 bits", last_bits, 24);
    check("R9 mosi", last_mosi, 24'h818A93);
    check("R9 fifo untouched", fifo_cnt, 0);

    // R11 push and pop in the same cycle while full
    fb = fr;
    do_start(2'd1, 8'h8F, 1'b0, 8'd16, 16'd0);
    wait_idle();
    check("R11 full", fifo_cnt, 16);
    f0 = fr;
    do_start(2'd0, 8'h8F, 1'b0, 8'd0, 16'd0);
    repeat (MIN_PER - 1) @(negedge clk);
    d = fifo_data;
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
    wait_idle();
    check("R11 head", d, pat(fb));
    check("R11 ovf clear", fifo_ovf, 0);
    check("R11 cnt", fifo_cnt, 16);

    // R10 overflow
    do_start(2'd0, 8'h8F, 1'b0, 8'd0, 16'd0);
    wait_idle();
    check("R10 ovf", fifo_ovf, 1);
    check("R10 cnt", fifo_cnt, 16);
    for (int k = 0; k < 16; k++) pop(d);
    check("R10 last kept", d, pat(f0));
    settle();
    check("R10 empty", fifo_empty, 1);
    check("R10 sticky", fifo_ovf, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule